// File: doc/BRIEF.md
# Age-Counter Victim Selector

This block decides which way of a set-associative cache receives a newly loaded block. For every line of every set it keeps a small relative-age counter. The ages of the valid lines in a set are always distinct: the youngest line holds 0 and the oldest holds the largest value. The surrounding cache keeps the tag and valid storage. Each cycle it presents a set index and that set's valid bits, and the block returns the way to fill, computed combinationally.

A fill strobe commits the load into the returned way. An access strobe with a way number reports a hit. A mode input selects the replacement order. In first-in-first-out mode, hits leave the ages untouched, so the oldest load is evicted. In least-recently-used mode, a hit makes the line the youngest, so the line touched longest ago is evicted. Each event updates its set in a single clock cycle.

Top module: `age_repl_sel`

## Requirements
- R1: After reset every age counter is 0. With all ages 0, the returned way is the lowest invalid way, or way 0 when the set is full.
- R2: When the presented set has at least one invalid line, the returned way is the lowest-numbered invalid way.
- R3: When every line of the set is valid, the returned way is the line with the greatest age.
- R4: On a fill, the age of the filled way becomes 0 and the age of every other valid line in that set rises by 1. As a result, successive fills of a full set cycle through the ways in load order.
- R5: With `lru_mode` = 0 (first-in-first-out), an access leaves every age unchanged, so a hit does not change the returned way.
- R6: With `lru_mode` = 1, an access to way h sets h's age to 0 and raises by 1 each valid line in the same set whose age was below h's old age.
- R7: When `fill_en` and `touch_en` are both high in the same cycle, only the fill is applied and the access is ignored.
- R8: Events on one set leave the ages of every other set unchanged.
- R9: With one way per set, the returned way is always 0.
- R10: `victim_way` depends combinationally on the present inputs and stored ages. Updates from a fill or an access become visible from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lru_mode | input | 1 | 0 = first-in-first-out, 1 = least-recently-used |
| set_idx | input | clog2(SETS) | Set addressed this cycle |
| line_valid | input | WAYS | Valid bits of the addressed set, bit w for way w |
| fill_en | input | 1 | Load a block into `victim_way` of the set |
| touch_en | input | 1 | Hit on `touch_way` of the set |
| touch_way | input | clog2(WAYS) | Way that hit |
| victim_way | output | clog2(WAYS) | Way chosen for the next fill |

## Verification
The hardest state to reach is a full set whose age order has been reshuffled by interleaved hits in least-recently-used mode. It is harder still when the mode has changed while ages from the other policy remain in place. The bench first drives directed fills and hits into one set so that the expected victim is known by hand. It then runs a long random phase over a few sets, with the mode flipped every couple of hundred cycles and coincident fill and hit strobes. A behavioural model of the ages predicts the returned way on every cycle.

// File: rtl/age_repl_sel.sv
module age_repl_sel #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            lru_mode,
  input  logic [SW-1:0]   set_idx,
  input  logic [WAYS-1:0] line_valid,
  input  logic            fill_en,
  input  logic            touch_en,
  input  logic [WW-1:0]   touch_way,
  output logic [WW-1:0]   victim_way
);

  logic [WW-1:0] age_q [SETS][WAYS];
  logic          any_free;
  logic [WW-1:0] free_way;
  logic [WW-1:0] old_way;
  logic [WW-1:0] hit_age;

  always_comb begin
    any_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!line_valid[w]) begin
        any_free = 1'b1;
        free_way = WW'(w);
      end
    end
    old_way = '0;
    for (int w = 1; w < WAYS; w++) begin
      if (age_q[set_idx][w] > age_q[set_idx][old_way]) old_way = WW'(w);
    end
  end

  assign victim_way = any_free ? free_way : old_way;
  assign hit_age    = age_q[set_idx][touch_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= '0;
    end else if (fill_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == victim_way)
          age_q[set_idx][w] <= '0;
        else if (line_valid[w])
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
    end else if (touch_en && lru_mode) begin
      for (int w = 0; w < WAYS; w++) begin
        if (WW'(w) == touch_way)
          age_q[set_idx][w] <= '0;
        else if (line_valid[w] && age_q[set_idx][w] < hit_age)
          age_q[set_idx][w] <= age_q[set_idx][w] + 1'b1;
      end
    end
  end

endmodule

module age_repl_chk #(
  parameter int SETS = 8,
  parameter int WAYS = 4,
  localparam int SW = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lru_mode,
  input logic [SW-1:0]   set_idx,
  input logic [WAYS-1:0] line_valid,
  input logic            fill_en,
  input logic            touch_en,
  input logic [WW-1:0]   touch_way,
  input logic [WW-1:0]   victim_way
);

  // R2
  free_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&line_valid) |-> !line_valid[victim_way]);

  // R5
  fifo_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lru_mode && touch_en && !fill_en) |=>
      (!$stable(set_idx) || !$stable(line_valid) || $stable(victim_way)));

  generate
    if (WAYS > 1) begin : g_multi
      // R4
      fill_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && &line_valid) |=>
          (!$stable(set_idx) || !(&line_valid) || victim_way != $past(victim_way)));
      // R6
      lru_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lru_mode && touch_en && !fill_en && &line_valid) |=>
          (!$stable(set_idx) || !(&line_valid) || victim_way != $past(touch_way)));
    end else begin : g_single
      // R9
      single_way_chk: assert property (@(posedge clk) disable iff (!rst_n)
        victim_way == '0);
    end
  endgenerate

endmodule

bind age_repl_sel age_repl_chk #(.SETS(SETS), .WAYS(WAYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode), .set_idx(set_idx),
  .line_valid(line_valid), .fill_en(fill_en), .touch_en(touch_en),
  .touch_way(touch_way), .victim_way(victim_way)
);

// File: tb/tb_age_repl_sel.sv
`timescale 1ns/1ps
module tb_age_repl_sel;
  localparam int SETS = 8;
  localparam int WAYS = 4;
  localparam int SW = 3;
  localparam int WW = 2;

  logic clk = 0, rst_n = 0, lru_mode = 0, fill_en = 0, touch_en = 0;
  logic [SW-1:0] set_idx = '0;
  logic [WAYS-1:0] line_valid = '0;
  logic [WW-1:0] touch_way = '0;
  logic [WW-1:0] victim_way;
  logic dm_valid = 0;
  logic dm_victim;

  int checks = 0, errors = 0;
  bit mvalid [SETS][WAYS];
  int mage [SETS][WAYS];

  always #2.5 clk = ~clk;

  age_repl_sel #(.SETS(SETS), .WAYS(WAYS)) dut (
    .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode), .set_idx(set_idx),
    .line_valid(line_valid), .fill_en(fill_en), .touch_en(touch_en),
    .touch_way(touch_way), .victim_way(victim_way));

  age_repl_sel #(.SETS(SETS), .WAYS(1)) dut_dm (
    .clk(clk), .rst_n(rst_n), .lru_mode(lru_mode), .set_idx(set_idx),
    .line_valid(dm_valid), .fill_en(fill_en), .touch_en(touch_en),
    .touch_way(1'b0), .victim_way(dm_victim));

  function automatic int model_victim(int s);
    int best = 0;
    for (int w = WAYS - 1; w >= 0; w--) if (!mvalid[s][w]) best = -1 - w;
    if (best < 0) return -1 - best;
    for (int w = 1; w < WAYS; w++) if (mage[s][w] > mage[s][best]) best = w;
    return best;
  endfunction

  task automatic check(int got, int exp, string tag);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: victim_way=%0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic step(int s, bit f, bit t, int tw, bit lm, string tag);
    int v;
    set_idx = SW'(s);
    for (int w = 0; w < WAYS; w++) line_valid[w] = mvalid[s][w];
    fill_en = f; touch_en = t; touch_way = WW'(tw); lru_mode = lm;
    dm_valid = $urandom_range(0, 1);
    #1;
    v = model_victim(s);
    check(int'(victim_way), v, tag);
    check(int'(dm_victim), 0, "R9");
    if (f) begin
      for (int w = 0; w < WAYS; w++) if (w != v && mvalid[s][w]) mage[s][w]++;
      mage[s][v] = 0;
      mvalid[s][v] = 1;
    end else if (t && lm) begin
      int old = mage[s][tw];
      for (int w = 0; w < WAYS; w++) if (w != tw && mvalid[s][w] && mage[s][w] < old) mage[s][w]++;
      mage[s][tw] = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin mvalid[s][w] = 0; mage[s][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    for (int i = 0; i < WAYS; i++) step(0, 1, 0, 0, 0, "R2");
    step(0, 0, 1, 0, 0, "R5");
    step(0, 0, 1, 3, 0, "R5");
    step(0, 0, 0, 0, 0, "R5");
    check(int'(victim_way), 0, "R5");
    step(1, 0, 0, 0, 0, "R8");
    step(0, 1, 0, 0, 0, "R4");
    step(0, 0, 1, 1, 1, "R6");
    step(0, 0, 0, 0, 1, "R10");
    check(int'(victim_way), 2, "R6");
    step(0, 1, 1, 2, 1, "R7");
    step(0, 0, 0, 0, 1, "R7");
    step(0, 1, 0, 0, 0, "R3");
    step(0, 1, 0, 0, 0, "R4");

    for (int i = 0; i < 3000; i++) begin
      int s = $urandom_range(0, 2);
      int tw = $urandom_range(0, WAYS - 1);
      bit f = ($urandom_range(0, 3) == 0);
      bit t = mvalid[s][tw] && ($urandom_range(0, 1) == 1);
      bit lm = ((i / 200) % 2) == 1;
      step(s, f, t, tw, lm, "R3/R4");
    end

    rst_n = 0;
    #1;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) mage[s][w] = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 0, 0, 0, "R1");
    step(1, 0, 0, 0, 1, "R1");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule